// File: doc/BRIEF.md
# I2C Master Byte Transfer Engine

This block is the byte-level core of an I2C bus master. The host loads a byte to send one address or data byte, most significant bit first, and the engine then samples the slave's acknowledge in the ninth clock. A receive command clocks in one byte from the slave instead. A third command sends a single acknowledge or not-acknowledge bit. An internal counter, set by the `HALF_PERIOD` parameter, times every SCL low phase and every SCL high phase. Start conditions, stop conditions and repeated starts are generated elsewhere. This engine takes over after a start, with SCL already held low.

Both bus lines are open-drain. An output-enable of 1 pulls the line low. SDA is read back through `sda_in`. Between bytes the counter stops and the bus stays frozen with SCL low. While the bus is frozen the host reads status or issues the next command. Commands given while a byte is in flight are refused. A refused write sets a sticky collision flag. A received byte that arrives while the buffer is still unread is dropped and sets a sticky overflow flag.

Top module: `i2c_byte_engine`

## Requirements
- R1: After reset, `scl_oe`=1 (SCL low), `sda_oe`=0, `rd_data`=0, and `buf_full`, `wcol`, `rov`, `ack_stat` and `irq` are all 0.
- R2: When idle, a `wr_stb` pulse accepted at edge k loads `wr_data` into the buffer and sets `buf_full`. Bit 7-i is driven on SDA from edge k+2·H·i to edge k+2·H·(i+1), with `sda_oe`=1 meaning a 0 bit. H is `HALF_PERIOD`.
- R3: Counted from edge k, SCL is low during [2jH, 2jH+H) and released during [2jH+H, 2jH+2H). This holds for 9 clocks on a transmit, 8 clocks on a receive and 1 clock on an acknowledge send. SCL then stays low.
- R4: On a transmit, at edge k+16H (the eighth falling edge), `buf_full` clears and SDA is released for the whole ninth clock.
- R5: SDA is sampled in the middle of the ninth high phase. At edge k+18H, `ack_stat` becomes 0 if the slave held SDA at 0 and becomes 1 otherwise. It changes at no other time.
- R6: A transmit sets `irq` at edge k+18H. The engine then stays idle with SCL low and SDA released until the next command.
- R7: A `wr_stb` while a byte is in flight sets `wcol` and leaves `rd_data` and the byte on the bus unchanged. Only `err_clr` clears `wcol`.
- R8: A `rcv_cmd` is ignored unless the engine is idle.
- R9: A receive accepted at edge k samples SDA in the middle of each high phase, MSB first. At edge k+16H it loads the byte into `rd_data` and sets `buf_full` and `irq`. It never drives SDA.
- R10: A `rd_stb` clears `buf_full`. If a receive completes while `buf_full` is set, `rov` is set and the new byte is dropped. Only `err_clr` clears `rov`.
- R11: When idle, `ack_cmd` drives `ack_val` on SDA for one clock of 2H cycles (0 = acknowledge, pulled low). At edge k+2H the engine returns to idle with SCL low and SDA released, without setting `irq`.
- R12: `irq_clr` clears `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | Write the transmit buffer and start a transmit |
| wr_data | input | 8 | Byte to transmit |
| rd_stb | input | 1 | Host read of the buffer; clears buffer-full |
| rcv_cmd | input | 1 | Start receiving one byte |
| ack_cmd | input | 1 | Send one acknowledge bit |
| ack_val | input | 1 | Acknowledge bit value to send (0 = ACK) |
| err_clr | input | 1 | Clear write-collision and overflow flags |
| irq_clr | input | 1 | Clear the interrupt flag |
| sda_in | input | 1 | Sensed SDA line level |
| rd_data | output | 8 | Buffer contents |
| scl_oe | output | 1 | Pull SCL low |
| sda_oe | output | 1 | Pull SDA low |
| buf_full | output | 1 | Buffer-full flag |
| wcol | output | 1 | Write-collision flag |
| rov | output | 1 | Receive-overflow flag |
| ack_stat | output | 1 | Last acknowledge result (1 = not acknowledged) |
| irq | output | 1 | Byte-complete interrupt flag |

## Verification
The bench builds the engine with `HALF_PERIOD` = 4, so one byte takes 64 to 72 cycles. At that size every one of the 256 byte values can be transmitted and received. Each SCL and SDA level in every cycle of every transfer is compared with the arithmetic timeline from the requirements. The acknowledge answer follows a bit pattern of the byte, so both acknowledge outcomes and the released ninth bit are covered. Refused writes, refused receive commands, back-to-back receives that overflow, and both acknowledge values sent by the master are placed at fixed cycle offsets within this sweep.

// File: rtl/i2c_eng_pkg.sv
package i2c_eng_pkg;

    localparam int unsigned BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_TX,
        ST_RX,
        ST_ACK
    } eng_state_e;

    typedef struct packed {
        logic buf_full;
        logic wcol;
        logic rov;
        logic ack_nack;
        logic irq;
    } eng_flags_t;

    // Number of SCL clocks each operation spends on the bus.
    function automatic logic [3:0] clocks_of(eng_state_e s);
        case (s)
            ST_TX:   return 4'd9;
            ST_RX:   return 4'd8;
            ST_ACK:  return 4'd1;
            default: return 4'd0;
        endcase
    endfunction

endpackage

// File: rtl/i2c_half_timer.sv
module i2c_half_timer #(
    parameter int unsigned HALF = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick,
    output logic mid
);
    localparam int unsigned CW  = (HALF > 2) ? $clog2(HALF) : 1;
    localparam int unsigned MID = HALF / 2;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF - 1));
    assign mid  = run && (cnt == CW'(MID));

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt == CW'(HALF - 1)) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/i2c_shift_reg.sv
module i2c_shift_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         shift,
    input  logic         shift_in,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (shift) begin
            q <= {q[W-2:0], shift_in};
        end
    end
endmodule

// File: rtl/i2c_byte_engine.sv
module i2c_byte_engine
    import i2c_eng_pkg::*;
#(
    parameter int unsigned HALF_PERIOD = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_stb,
    input  logic [BYTE_W-1:0]   wr_data,
    input  logic                rd_stb,
    input  logic                rcv_cmd,
    input  logic                ack_cmd,
    input  logic                ack_val,
    input  logic                err_clr,
    input  logic                irq_clr,
    input  logic                sda_in,
    output logic [BYTE_W-1:0]   rd_data,
    output logic                scl_oe,
    output logic                sda_oe,
    output logic                buf_full,
    output logic                wcol,
    output logic                rov,
    output logic                ack_stat,
    output logic                irq
);
    eng_state_e        state;
    eng_flags_t        flg;
    logic              scl_hi;
    logic [3:0]        clk_idx;
    logic [3:0]        next_idx;
    logic              sda_drv;
    logic              samp;
    logic [BYTE_W-1:0] buf_q;
    logic [BYTE_W-1:0] sh_q;

    logic busy, tick, mid, fall, rise, done;
    logic accept_wr, accept_rcv, accept_ack;
    logic tx_release, tx_done, rx_done, rx_drop;
    logic sh_shift, sh_in;

    assign busy     = (state != ST_IDLE);
    assign fall     = tick && scl_hi;
    assign rise     = tick && !scl_hi;
    assign next_idx = clk_idx + 4'd1;
    assign done     = fall && (next_idx == clocks_of(state));

    assign accept_wr  = wr_stb && !busy;
    assign accept_rcv = rcv_cmd && !busy && !wr_stb;
    assign accept_ack = ack_cmd && !busy && !wr_stb && !rcv_cmd;

    assign tx_release = (state == ST_TX) && fall && (next_idx == 4'd8);
    assign tx_done    = (state == ST_TX) && done;
    assign rx_done    = (state == ST_RX) && done;
    assign rx_drop    = rx_done && flg.buf_full && !rd_stb;

    assign sh_shift = ((state == ST_TX) && fall) ||
                      ((state == ST_RX) && scl_hi && mid);
    assign sh_in    = (state == ST_RX) ? sda_in : 1'b0;

    i2c_half_timer #(.HALF(HALF_PERIOD)) u_timer (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .tick (tick),
        .mid  (mid)
    );

    i2c_shift_reg #(.W(BYTE_W)) u_shift (
        .clk      (clk),
        .rst      (rst),
        .load     (accept_wr),
        .load_val (wr_data),
        .shift    (sh_shift),
        .shift_in (sh_in),
        .q        (sh_q)
    );

    // Bus sequencing
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            scl_hi  <= 1'b0;
            clk_idx <= '0;
            sda_drv <= 1'b0;
            samp    <= 1'b1;
        end else if (!busy) begin
            clk_idx <= '0;
            if (accept_wr) begin
                state   <= ST_TX;
                sda_drv <= ~wr_data[BYTE_W-1];
            end else if (accept_rcv) begin
                state   <= ST_RX;
                sda_drv <= 1'b0;
            end else if (accept_ack) begin
                state   <= ST_ACK;
                sda_drv <= ~ack_val;
            end
        end else begin
            if (scl_hi && mid) begin
                samp <= sda_in;
            end
            if (rise) begin
                scl_hi <= 1'b1;
            end
            if (fall) begin
                scl_hi  <= 1'b0;
                clk_idx <= next_idx;
                if (done) begin
                    state   <= ST_IDLE;
                    sda_drv <= 1'b0;
                    clk_idx <= '0;
                end else if (state == ST_TX) begin
                    sda_drv <= (next_idx < 4'd8) ? ~sh_q[BYTE_W-2] : 1'b0;
                end
            end
        end
    end

    // Host-visible flags and buffer
    always_ff @(posedge clk) begin
        if (rst) begin
            flg   <= '0;
            buf_q <= '0;
        end else begin
            if (rd_stb)           flg.buf_full <= 1'b0;
            if (accept_wr)        flg.buf_full <= 1'b1;
            if (tx_release)       flg.buf_full <= 1'b0;
            if (rx_done)          flg.buf_full <= 1'b1;

            if (err_clr)          flg.wcol <= 1'b0;
            if (wr_stb && busy)   flg.wcol <= 1'b1;

            if (err_clr)          flg.rov <= 1'b0;
            if (rx_drop)          flg.rov <= 1'b1;

            if (tx_done)          flg.ack_nack <= samp;

            if (irq_clr)          flg.irq <= 1'b0;
            if (tx_done || rx_done) flg.irq <= 1'b1;

            if (accept_wr) begin
                buf_q <= wr_data;
            end else if (rx_done && !rx_drop) begin
                buf_q <= sh_q;
            end
        end
    end

    assign rd_data  = buf_q;
    assign scl_oe   = ~scl_hi;
    assign sda_oe   = sda_drv;
    assign buf_full = flg.buf_full;
    assign wcol     = flg.wcol;
    assign rov      = flg.rov;
    assign ack_stat = flg.ack_nack;
    assign irq      = flg.irq;

endmodule

// File: rtl/i2c_byte_engine_chk.sv
module i2c_byte_engine_chk (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic wr_stb,
    input logic rd_stb,
    input logic err_clr,
    input logic scl_oe,
    input logic sda_oe,
    input logic buf_full,
    input logic wcol,
    input logic rov,
    input logic ack_stat
);
    // R6: frozen bus between bytes
    p_idle_scl_low_r6: assert property (@(posedge clk) disable iff (rst)
        !busy |-> scl_oe);
    p_idle_sda_free_r6: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !sda_oe);

    // R7: refused write is flagged and stays flagged until cleared
    p_wcol_set_r7: assert property (@(posedge clk) disable iff (rst)
        busy && wr_stb |=> wcol);
    p_wcol_hold_r7: assert property (@(posedge clk) disable iff (rst)
        wcol && !err_clr |=> wcol);

    // R10: overflow is sticky, a read empties the buffer
    p_rov_hold_r10: assert property (@(posedge clk) disable iff (rst)
        rov && !err_clr |=> rov);
    p_rd_clear_r10: assert property (@(posedge clk) disable iff (rst)
        rd_stb && !wr_stb && !busy |=> !buf_full);

    // R5: acknowledge status only moves at the end of a transfer
    p_ack_at_end_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(ack_stat) |-> $past(busy));
endmodule

bind i2c_byte_engine i2c_byte_engine_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .busy     (busy),
    .wr_stb   (wr_stb),
    .rd_stb   (rd_stb),
    .err_clr  (err_clr),
    .scl_oe   (scl_oe),
    .sda_oe   (sda_oe),
    .buf_full (buf_full),
    .wcol     (wcol),
    .rov      (rov),
    .ack_stat (ack_stat)
);

// File: tb/test_i2c_byte_engine.sv
module test_i2c_byte_engine;
    localparam int H = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_stb = 1'b0, rd_stb = 1'b0, rcv_cmd = 1'b0, ack_cmd = 1'b0;
    logic       ack_val = 1'b0, err_clr = 1'b0, irq_clr = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       slave_pull = 1'b0;
    logic       sda_in;
    logic [7:0] rd_data;
    logic       scl_oe, sda_oe, buf_full, wcol, rov, ack_stat, irq;

    int errs = 0;
    int checks = 0;

    assign sda_in = !(sda_oe || slave_pull);

    always #4 clk = ~clk;

    i2c_byte_engine #(.HALF_PERIOD(H)) i_i2c_byte_engine (
        .clk(clk), .rst(rst), .wr_stb(wr_stb), .wr_data(wr_data),
        .rd_stb(rd_stb), .rcv_cmd(rcv_cmd), .ack_cmd(ack_cmd),
        .ack_val(ack_val), .err_clr(err_clr), .irq_clr(irq_clr),
        .sda_in(sda_in), .rd_data(rd_data), .scl_oe(scl_oe),
        .sda_oe(sda_oe), .buf_full(buf_full), .wcol(wcol), .rov(rov),
        .ack_stat(ack_stat), .irq(irq)
    );

    task automatic chk(input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // 0: irq_clr, 1: err_clr, 2: rd_stb
    task automatic host_pulse(input int which);
        @(negedge clk);
        case (which)
            0: irq_clr = 1'b1;
            1: err_clr = 1'b1;
            default: rd_stb = 1'b1;
        endcase
        @(posedge clk);
        @(negedge clk);
        irq_clr = 1'b0;
        err_clr = 1'b0;
        rd_stb  = 1'b0;
    endtask

    task automatic run_tx(input logic [7:0] b, input bit slave_ack, input bit poke);
        int falls = 0;
        int rises = 0;
        int bad_scl = 0;
        int bad_sda = 0;
        logic [8:0] cap = '0;
        bit prev_scl = 1'b0;
        bit scl, exp_low, exp_oe;
        int total = 18 * H;
        @(negedge clk);
        wr_data = b;
        wr_stb = 1'b1;
        slave_pull = 1'b0;
        @(posedge clk);
        @(negedge clk);
        for (int n = 0; n <= total + 4 * H; n++) begin
            if (n > 0) begin
                @(posedge clk);
                @(negedge clk);
            end
            wr_stb = 1'b0;
            rcv_cmd = 1'b0;
            if (n == 0) chk("R2", "buf_full after write", buf_full, 1);
            scl = !scl_oe;
            if (scl && !prev_scl) begin
                cap = {cap[7:0], sda_in};
                rises++;
            end
            if (!scl && prev_scl) falls++;
            prev_scl = scl;
            slave_pull = slave_ack && (falls == 8);
            exp_low = (n >= total) ? 1'b1 : (((n / H) % 2) == 0);
            if (scl_oe != exp_low) bad_scl++;
            exp_oe = (n < 16 * H) ? !b[7 - n / (2 * H)] : 1'b0;
            if (sda_oe != exp_oe) bad_sda++;
            if (n == 16 * H - 1) chk("R4", "buf_full before 8th fall", buf_full, 1);
            if (n == 16 * H) chk("R4", "buf_full at 8th fall", buf_full, 0);
            if (n == total - 1) chk("R6", "irq before 9th fall", irq, 0);
            if (n == total) begin
                chk("R6", "irq at 9th fall", irq, 1);
                chk("R5", "ack_stat", ack_stat, slave_ack ? 0 : 1);
            end
            if (poke && n == 3 * H) begin
                wr_data = ~b;
                wr_stb = 1'b1;
                rcv_cmd = 1'b1;
            end
        end
        slave_pull = 1'b0;
        chk("R3", "scl timeline mismatches", bad_scl, 0);
        chk("R2", "sda timeline mismatches (tx bits, R6 frozen)", bad_sda, 0);
        chk("R2", "byte seen on bus", cap[8:1], b);
        chk("R4", "ninth bit line level", cap[0], slave_ack ? 0 : 1);
        chk("R3", "scl rising edges", rises, 9);
        if (poke) begin
            chk("R7", "wcol after busy write", wcol, 1);
            chk("R7", "buffer kept", rd_data, b);
            chk("R8", "receive command ignored (scl frozen)", bad_scl, 0);
        end
    endtask

    task automatic run_rx(input logic [7:0] b, input logic [7:0] exp_rd, input bit exp_rov);
        int falls = 0;
        int bad_scl = 0;
        int bad_sda = 0;
        bit prev_scl = 1'b0;
        bit scl, exp_low;
        int total = 16 * H;
        @(negedge clk);
        rcv_cmd = 1'b1;
        slave_pull = !b[7];
        @(posedge clk);
        @(negedge clk);
        for (int n = 0; n <= total + 2 * H; n++) begin
            if (n > 0) begin
                @(posedge clk);
                @(negedge clk);
            end
            rcv_cmd = 1'b0;
            scl = !scl_oe;
            if (!scl && prev_scl) falls++;
            prev_scl = scl;
            slave_pull = (falls < 8) ? !b[7 - falls] : 1'b0;
            exp_low = (n >= total) ? 1'b1 : (((n / H) % 2) == 0);
            if (scl_oe != exp_low) bad_scl++;
            if (sda_oe != 1'b0) bad_sda++;
            if (n == total - 1) chk("R9", "irq before 8th fall", irq, 0);
            if (n == total) begin
                chk("R9", "irq at 8th fall", irq, 1);
                chk("R9", "buf_full at 8th fall", buf_full, 1);
                chk("R9", "received byte", rd_data, exp_rd);
                chk("R10", "overflow flag", rov, exp_rov ? 1 : 0);
            end
        end
        slave_pull = 1'b0;
        chk("R3", "rx scl timeline mismatches", bad_scl, 0);
        chk("R9", "rx sda never driven", bad_sda, 0);
    endtask

    task automatic run_ack(input bit val);
        int bad_scl = 0;
        int bad_sda = 0;
        bit prev_scl = 1'b0;
        bit scl, exp_low, exp_oe;
        bit seen = 1'b1;
        int total = 2 * H;
        @(negedge clk);
        ack_cmd = 1'b1;
        ack_val = val;
        @(posedge clk);
        @(negedge clk);
        for (int n = 0; n <= total + 2 * H; n++) begin
            if (n > 0) begin
                @(posedge clk);
                @(negedge clk);
            end
            ack_cmd = 1'b0;
            scl = !scl_oe;
            if (scl && !prev_scl) seen = sda_in;
            prev_scl = scl;
            exp_low = (n >= total) ? 1'b1 : (((n / H) % 2) == 0);
            if (scl_oe != exp_low) bad_scl++;
            exp_oe = (n < total) ? !val : 1'b0;
            if (sda_oe != exp_oe) bad_sda++;
        end
        chk("R11", "ack scl timeline mismatches", bad_scl, 0);
        chk("R11", "ack sda timeline mismatches", bad_sda, 0);
        chk("R11", "ack bit on bus", seen, val);
        chk("R11", "no irq from ack send", irq, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "scl_oe", scl_oe, 1);
        chk("R1", "sda_oe", sda_oe, 0);
        chk("R1", "rd_data", rd_data, 0);
        chk("R1", "flags", {buf_full, wcol, rov, ack_stat, irq}, 0);

        // Transmit sweep over all byte values
        for (int v = 0; v < 256; v++) begin
            logic [7:0] b;
            b = 8'(v);
            host_pulse(0);
            chk("R12", "irq cleared", irq, 0);
            run_tx(b, b[0] ^ b[4], (v % 37) == 5);
            if ((v % 37) == 5) begin
                chk("R7", "wcol held until cleared", wcol, 1);
                host_pulse(1);
                chk("R7", "wcol cleared by host", wcol, 0);
            end
        end

        // Receive sweep over all byte values, each read back
        for (int v = 0; v < 256; v++) begin
            logic [7:0] b;
            b = 8'(v ^ 8'h5A);
            host_pulse(0);
            run_rx(b, b, 1'b0);
            host_pulse(2);
            chk("R10", "buf_full cleared by read", buf_full, 0);
        end

        // Overflow: second byte arrives before the first is read
        host_pulse(0);
        run_rx(8'hA5, 8'hA5, 1'b0);
        host_pulse(0);
        run_rx(8'h3C, 8'hA5, 1'b1);
        host_pulse(2);
        chk("R10", "buf_full cleared after overflow read", buf_full, 0);
        chk("R10", "rov held until cleared", rov, 1);
        host_pulse(1);
        chk("R10", "rov cleared by host", rov, 0);

        // Acknowledge send, both values
        host_pulse(0);
        run_ack(1'b0);
        run_ack(1'b1);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule